// File: doc/BRIEF.md
# Slave Sync Field Decoder

This block sits behind the timing inputs of a video encoder running in slave mode. It receives active-low horizontal and vertical sync from an external timing source, plus an optional active-low blanking input. It works out which field is starting, odd or even, from how the two sync edges line up. It also numbers the lines of a 525-line frame and produces a blanking flag. When external blanking is switched off, the flag comes from the line number.

All three inputs are resynchronised through a two-stage flip-flop chain on the rising pixel clock, and then edge-detected. Two cases start a field. If both syncs fall in the same sampled cycle, an odd field starts. If vertical sync falls while horizontal sync is high, an even field starts. A vertical fall while horizontal sync is already low is not a valid field start and is ignored.

Every horizontal sync fall advances the line number. A data-latch enable tells the pixel path on which rising edges to capture data: in slave mode, outside blanking.

Top module: `slave_field_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, `field_start`, `field_even`, `blank_flag` and `data_latch_en` read 0 and `line_num` reads 0 afterwards.
- R2: When `hsync_n` and `vsync_n` fall in the same sampled cycle, an odd field starts. On the third rising edge after the inputs change, `field_start` is 1, `field_even` is 0 and `line_num` is 1.
- R3: When `vsync_n` falls while `hsync_n` is high, an even field starts. With the same three-edge latency, `field_start` is 1, `field_even` is 1 and `line_num` is 263.
- R4: A `vsync_n` fall while `hsync_n` is already low (and not falling in that cycle) gives no `field_start` pulse and leaves `field_even` and `line_num` unchanged.
- R5: Each `hsync_n` fall that does not start a field increments `line_num` with three-edge latency. After 525 it wraps to 1.
- R6: `field_even` keeps its value until the next valid field start.
- R7: `field_start` is high for exactly one clock cycle per field start.
- R8: Field starts and line steps are acted on only while `mode_sel` equals 3'b100. In any other value they are ignored: `line_num` and `field_even` hold, and no pulse occurs.
- R9: With `ext_blank_en` = 0, `blank_flag` is 1 exactly when `line_num` lies in 1..21, 260..284 or 522..525. The flag is updated in the same cycle as `line_num`.
- R10: With `ext_blank_en` = 1, `blank_flag` is the inverse of `blank_n`, three rising edges after `blank_n` changes, whatever the line number.
- R11: `data_latch_en` is 1 exactly when `mode_sel` equals 3'b100 and `blank_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Timing mode; 3'b100 selects slave decoding |
| ext_blank_en | input | 1 | 1: use `blank_n`; 0: blank from line number |
| hsync_n | input | 1 | External horizontal sync, active low |
| vsync_n | input | 1 | External vertical sync, active low |
| blank_n | input | 1 | External blanking, active low |
| field_start | output | 1 | One-cycle pulse at each valid field start |
| field_even | output | 1 | Current field parity, 1 = even |
| line_num | output | LINE_W (10) | Current line number, 1..525 |
| blank_flag | output | 1 | Line is blanked |
| data_latch_en | output | 1 | Enable for latching pixel data |

## Verification
An input change applied at a falling edge passes through two synchroniser stages and the output register. Every result from sync or blanking inputs is therefore due at the third rising edge after the change. A mode or blank-source change is due at the first rising edge. The driver tasks push each expected output set into a queue, stamped with the cycle number at which it is due. The monitor pops and compares it at the falling edge of exactly that cycle, which keeps sampling away from the register updates. For each field start the bench also queues a second item one cycle later, expecting the pulse to have dropped.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    // Mode code that selects slave decoding of external syncs
    localparam logic [2:0] SLAVE_MODE = 3'b100;

    // Classified result of one sampled cycle of sync edges
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_ODD  = 2'd1,
        EV_EVEN = 2'd2,
        EV_LINE = 2'd3
    } sync_event_e;

    // Level and edge view of the resynchronised syncs
    typedef struct packed {
        logic h_fall;
        logic v_fall;
        logic h_level;
    } sync_edges_t;

    function automatic logic in_span(input int unsigned val,
                                     input int unsigned lo,
                                     input int unsigned hi);
        return (val >= lo) && (val <= hi);
    endfunction

endpackage

// File: rtl/sfd_sync.sv
module sfd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[gi] <= '1;
                    else     stage_q[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[gi] <= '1;
                    else     stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sfd_edge_classify.sv
module sfd_edge_classify
    import sfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        hs_n,
    input  logic        vs_n,
    output sync_event_e event_o
);
    logic        hs_prev_q;
    logic        vs_prev_q;
    sync_edges_t edges;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_prev_q <= 1'b1;
            vs_prev_q <= 1'b1;
        end else begin
            hs_prev_q <= hs_n;
            vs_prev_q <= vs_n;
        end
    end

    always_comb begin
        edges.h_fall  = hs_prev_q & ~hs_n;
        edges.v_fall  = vs_prev_q & ~vs_n;
        edges.h_level = hs_n;
    end

    always_comb begin
        event_o = EV_NONE;
        if (enable) begin
            if (edges.v_fall && edges.h_fall)       event_o = EV_ODD;
            else if (edges.v_fall && edges.h_level) event_o = EV_EVEN;
            else if (edges.h_fall)                  event_o = EV_LINE;
            else                                    event_o = EV_NONE;
        end
    end
endmodule

// File: rtl/sfd_line_counter.sv
module sfd_line_counter
    import sfd_pkg::*;
#(
    parameter int LINES     = 525,
    parameter int ODD_LOAD  = 1,
    parameter int EVEN_LOAD = 263,
    parameter int LINE_W    = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_event_e       event_i,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] line_next,
    output logic              field_even_q,
    output logic              field_start_q
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES);
    localparam logic [LINE_W-1:0] ODD_VAL   = LINE_W'(ODD_LOAD);
    localparam logic [LINE_W-1:0] EVEN_VAL  = LINE_W'(EVEN_LOAD);

    always_comb begin
        case (event_i)
            EV_ODD:  line_next = ODD_VAL;
            EV_EVEN: line_next = EVEN_VAL;
            EV_LINE: line_next = (line_q == LAST_LINE) ? LINE_W'(1) : line_q + 1'b1;
            default: line_next = line_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q        <= '0;
            field_even_q  <= 1'b0;
            field_start_q <= 1'b0;
        end else begin
            line_q        <= line_next;
            field_start_q <= (event_i == EV_ODD) || (event_i == EV_EVEN);
            if (event_i == EV_ODD)       field_even_q <= 1'b0;
            else if (event_i == EV_EVEN) field_even_q <= 1'b1;
        end
    end

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        line_q <= LAST_LINE) else $error("line out of range"); // R5

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!field_start_q && line_q != $past(line_q))
            |-> (line_q == $past(line_q) + 1'b1) || (line_q == LINE_W'(1)))
        else $error("line moved by other than one"); // R5
endmodule

// File: rtl/sfd_blank_gen.sv
module sfd_blank_gen
    import sfd_pkg::*;
#(
    parameter int LINES       = 525,
    parameter int TOP_LAST    = 21,
    parameter int MID_FIRST   = 260,
    parameter int MID_LAST    = 284,
    parameter int TAIL_FIRST  = 522,
    parameter int LINE_W      = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_en,
    input  logic              ext_blank_n,
    input  logic              slave_on,
    input  logic [LINE_W-1:0] line_next,
    output logic              blank_q,
    output logic              latch_q
);
    logic auto_blank;
    logic blank_d;

    always_comb begin
        auto_blank = in_span(int'(line_next), 1, TOP_LAST)
                   | in_span(int'(line_next), MID_FIRST, MID_LAST)
                   | in_span(int'(line_next), TAIL_FIRST, LINES);
        blank_d    = ext_en ? ~ext_blank_n : auto_blank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            blank_q <= blank_d;
            latch_q <= slave_on & ~blank_d;
        end
    end
endmodule

// File: rtl/slave_field_decoder.sv
module slave_field_decoder
    import sfd_pkg::*;
#(
    parameter int LINES       = 525,
    parameter int ODD_LOAD    = 1,
    parameter int EVEN_LOAD   = 263,
    parameter int TOP_LAST    = 21,
    parameter int MID_FIRST   = 260,
    parameter int MID_LAST    = 284,
    parameter int TAIL_FIRST  = 522,
    parameter int SYNC_STAGES = 2,
    parameter int LINE_W      = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_sel,
    input  logic              ext_blank_en,
    input  logic              hsync_n,
    input  logic              vsync_n,
    input  logic              blank_n,
    output logic              field_start,
    output logic              field_even,
    output logic [LINE_W-1:0] line_num,
    output logic              blank_flag,
    output logic              data_latch_en
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              slave_on;
    sync_event_e       evt;
    logic [LINE_W-1:0] line_next;

    assign raw_bus  = {blank_n, vsync_n, hsync_n};
    assign slave_on = (mode_sel == SLAVE_MODE);

    sfd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_bus),
        .dout (sync_bus)
    );

    sfd_edge_classify u_edges (
        .clk     (clk),
        .rst     (rst),
        .enable  (slave_on),
        .hs_n    (sync_bus[0]),
        .vs_n    (sync_bus[1]),
        .event_o (evt)
    );

    sfd_line_counter #(
        .LINES     (LINES),
        .ODD_LOAD  (ODD_LOAD),
        .EVEN_LOAD (EVEN_LOAD),
        .LINE_W    (LINE_W)
    ) u_lines (
        .clk           (clk),
        .rst           (rst),
        .event_i       (evt),
        .line_q        (line_num),
        .line_next     (line_next),
        .field_even_q  (field_even),
        .field_start_q (field_start)
    );

    sfd_blank_gen #(
        .LINES      (LINES),
        .TOP_LAST   (TOP_LAST),
        .MID_FIRST  (MID_FIRST),
        .MID_LAST   (MID_LAST),
        .TAIL_FIRST (TAIL_FIRST),
        .LINE_W     (LINE_W)
    ) u_blank (
        .clk         (clk),
        .rst         (rst),
        .ext_en      (ext_blank_en),
        .ext_blank_n (sync_bus[2]),
        .slave_on    (slave_on),
        .line_next   (line_next),
        .blank_q     (blank_flag),
        .latch_q     (data_latch_en)
    );

    AST_ODD_LOADS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (field_start && !field_even) |-> line_num == LINE_W'(ODD_LOAD))
        else $error("odd start line"); // R2

    AST_EVEN_LOADS_MID: assert property (@(posedge clk) disable iff (rst)
        (field_start && field_even) |-> line_num == LINE_W'(EVEN_LOAD))
        else $error("even start line"); // R3

    AST_PARITY_HELD: assert property (@(posedge clk) disable iff (rst)
        !field_start |-> $stable(field_even))
        else $error("parity moved without start"); // R6

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        field_start |=> !field_start)
        else $error("start wider than one cycle"); // R7

    AST_OFF_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_sel) != SLAVE_MODE) |-> !field_start)
        else $error("start outside slave mode"); // R8

    AST_ODD_TOP_BLANK: assert property (@(posedge clk) disable iff (rst)
        (field_start && !field_even && !$past(ext_blank_en)) |-> blank_flag)
        else $error("first line not blanked"); // R9
endmodule

// File: tb/slave_field_decoder_tb_top.sv
module slave_field_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    typedef struct {
        int    due;
        string tag;
        logic  fs;
        logic  fe;
        int    line;
        logic  bl;
        logic  le;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'b100;
    logic       ext_blank_en = 1'b0;
    logic       hsync_n = 1'b1;
    logic       vsync_n = 1'b1;
    logic       blank_n = 1'b1;
    logic       field_start;
    logic       field_even;
    logic [9:0] line_num;
    logic       blank_flag;
    logic       data_latch_en;

    int   cyc = 0;
    int   vectors = 0;
    int   miscompares = 0;
    exp_t sb[$];

    // bench model
    int   m_line = 0;
    logic m_even = 1'b0;
    logic m_on   = 1'b1;
    logic m_ext  = 1'b0;
    logic m_bn   = 1'b1;

    slave_field_decoder dut_i (
        .clk           (clk),
        .rst           (rst),
        .mode_sel      (mode_sel),
        .ext_blank_en  (ext_blank_en),
        .hsync_n       (hsync_n),
        .vsync_n       (vsync_n),
        .blank_n       (blank_n),
        .field_start   (field_start),
        .field_even    (field_even),
        .line_num      (line_num),
        .blank_flag    (blank_flag),
        .data_latch_en (data_latch_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic vb(input int l);
        return (l >= 1 && l <= 21) || (l >= 260 && l <= 284) || (l >= 522 && l <= 525);
    endfunction

    function automatic logic m_blank();
        return m_ext ? ~m_bn : vb(m_line);
    endfunction

    task automatic push(input int delay, input string tag, input logic fs);
        exp_t e;
        e.due  = cyc + delay;
        e.tag  = tag;
        e.fs   = fs;
        e.fe   = m_even;
        e.line = m_line;
        e.bl   = m_blank();
        e.le   = m_on & ~m_blank();
        sb.push_back(e);
    endtask

    // kind: 0 no event expected, 1 odd start, 2 even start, 3 line step
    task automatic drive(input logic h, input logic v, input int kind, input string tag);
        @(negedge clk);
        hsync_n = h;
        vsync_n = v;
        if (m_on) begin
            if (kind == 1) begin m_line = 1; m_even = 1'b0; end
            else if (kind == 2) begin m_line = 263; m_even = 1'b1; end
            else if (kind == 3) m_line = (m_line == 525) ? 1 : m_line + 1;
        end
        push(LAT, tag, m_on && (kind == 1 || kind == 2));
        if (m_on && (kind == 1 || kind == 2)) push(LAT + 1, {tag, "_R7_drop"}, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_syncs();
        @(negedge clk);
        hsync_n = 1'b1;
        vsync_n = 1'b1;
        idle(2);
    endtask

    task automatic line_pulse(input string tag);
        drive(1'b0, 1'b1, 3, tag);
        idle(1);
        release_syncs();
    endtask

    task automatic check_now(input string tag);
        @(negedge clk);
        push(1, tag, 1'b0);
    endtask

    // monitor: compare each item in the cycle it is due
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (field_start !== e.fs || field_even !== e.fe || int'(line_num) != e.line ||
                    blank_flag !== e.bl || data_latch_en !== e.le) begin
                    miscompares++;
                    $display("FAIL %s: act fs=%0b fe=%0b line=%0d blank=%0b latch=%0b exp fs=%0b fe=%0b line=%0d blank=%0b latch=%0b",
                             e.tag, field_start, field_even, line_num, blank_flag, data_latch_en,
                             e.fs, e.fe, e.line, e.bl, e.le);
                end
            end
        end
    end

    // watchdog
    initial begin
        wait (cyc > 200000);
        miscompares++;
        $display("FAIL watchdog: act cycles=%0d exp under 200000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1 reset state, sampled while reset is still held
        idle(3);
        m_on = 1'b0;
        push(1, "R1_reset", 1'b0);
        m_on = 1'b1;
        idle(1);
        @(negedge clk);
        rst = 1'b0;
        idle(4);
        check_now("R11_latch_open");

        // R2 odd start, then lines crossing the top blank boundary (R5, R9, R6)
        drive(1'b0, 1'b0, 1, "R2_odd_start");
        idle(1);
        release_syncs();
        for (int i = 0; i < 25; i++) line_pulse("R5_R9_odd_lines");

        // R4 vsync falling while hsync already low: line step only
        drive(1'b0, 1'b1, 3, "R4_hsync_first");
        drive(1'b0, 1'b0, 0, "R4_vfall_ignored");
        idle(2);
        release_syncs();
        check_now("R4_parity_kept");

        // R3 even start, then run to the end of the frame and wrap (R5, R9, R6)
        drive(1'b1, 1'b0, 2, "R3_even_start");
        idle(1);
        release_syncs();
        for (int i = 0; i < 262; i++) line_pulse("R5_R9_even_lines");
        line_pulse("R5_wrap");

        // R8 other mode: edges ignored, latch closed (R11)
        @(negedge clk);
        mode_sel = 3'b011;
        m_on = 1'b0;
        idle(3);
        check_now("R8_R11_off_mode");
        drive(1'b0, 1'b0, 1, "R8_odd_ignored");
        idle(1);
        release_syncs();
        line_pulse("R8_line_ignored");
        drive(1'b1, 1'b0, 2, "R8_even_ignored");
        idle(1);
        release_syncs();
        @(negedge clk);
        mode_sel = 3'b100;
        m_on = 1'b1;
        idle(3);
        check_now("R11_back_on");

        // R6 back to odd after even; line 1 is auto-blanked (R9)
        drive(1'b0, 1'b0, 1, "R6_odd_again");
        idle(1);
        release_syncs();

        // R10 external blanking overrides line-based blanking
        @(negedge clk);
        ext_blank_en = 1'b1;
        m_ext = 1'b1;
        idle(3);
        check_now("R10_ext_clear_on_blank_line");
        @(negedge clk);
        blank_n = 1'b0;
        m_bn = 1'b0;
        push(LAT, "R10_ext_assert", 1'b0);
        idle(4);
        @(negedge clk);
        blank_n = 1'b1;
        m_bn = 1'b1;
        push(LAT, "R10_ext_release", 1'b0);
        idle(4);
        line_pulse("R10_line_under_ext");

        idle(8);
        if (sb.size() > 0) begin
            miscompares += sb.size();
            $display("FAIL pending: act %0d items left exp 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule